// File: doc/BRIEF.md
# Component-wise Complex Multiply/Divide Unit

This block takes a stream of complex sample pairs (X, Y) and returns one complex result per pair. In product mode the result is the complex product X·Y. In the two divide modes each complex X is scaled by the inverse of an 8-bit unsigned real divisor. The divisor is taken either from the low byte of the Y real part, so that it follows a vector, or from a scalar configuration field. The inverse comes from a 256-entry table that is computed at elaboration. Either operand can be conjugated before use, and the result can be conjugated before it leaves the block.

All samples are signed Q1.15: 16 bits real and 16 bits imaginary. Results are rounded back to Q1.15 and saturate on overflow. A division by zero gives a fixed saturated value and raises a per-sample error flag. Input and output use valid/ready handshakes. The pipeline has three register stages that advance together, so the whole pipeline stalls when the consumer stalls. A last-sample marker and the error flag travel with their sample. The configuration inputs are sampled together with each accepted sample.

Top module: `cvec_muldiv`

## Requirements
- R1: With cfg_mode = 0, the result is re = (xr·yr − xi·yi + 2^14) >> 15 and im = (xr·yi + xi·yr + 2^14) >> 15. The shift is arithmetic, so the rounding is half-up. Each part is then clamped to [−32768, 32767].
- R2: A product that leaves the Q1.15 range saturates instead of wrapping. (−1)·(−1) gives re = 32767 and im = 0.
- R3: cfg_conj_x = 1 negates the X imaginary part before use, and cfg_conj_y = 1 does the same for Y. Negating −32768 yields 32767.
- R4: cfg_conj_z = 1 negates the imaginary part of the rounded result, with the same saturation as R3.
- R5: With cfg_mode = 1, the divisor d is in_y_re[7:0], read as unsigned. For d ≠ 0, r = floor((65536 + floor(d/2)) / d), and each part of the result is (x·r + 32768) >> 16, then clamped. Conjugation of X (R3) applies first.
- R6: With cfg_mode = 2, the divisor is cfg_divisor and the Y inputs have no effect on the result.
- R7: In either divide mode, a divisor of 0 forces out_re = out_im = 32767 and out_err = 1, whatever cfg_conj_z is set to. In every other case out_err = 0.
- R8: When out_ready stays high, a sample accepted on a rising edge appears with out_valid = 1 after the second following rising edge. Samples leave in arrival order, none is lost or repeated, and out_last repeats in_last for that sample.
- R9: While out_valid = 1 and out_ready = 0, all outputs hold their values. Starting from empty, the unit accepts exactly three samples under a stall and then drives in_ready = 0.
- R10: After a clock edge with rst_n = 0, out_valid = 0 and in_ready = 1.
- R11: cfg_mode = 3 behaves exactly like cfg_mode = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample pair is valid |
| in_ready | output | 1 | Unit can take a sample this cycle |
| in_x_re | input | 16 | X real part, Q1.15 |
| in_x_im | input | 16 | X imaginary part, Q1.15 |
| in_y_re | input | 16 | Y real part, Q1.15; low byte is the divisor in mode 1 |
| in_y_im | input | 16 | Y imaginary part, Q1.15 |
| in_last | input | 1 | Marks the final sample of a vector |
| cfg_mode | input | 2 | 0/3 product, 1 divide by vector byte, 2 divide by scalar |
| cfg_conj_x | input | 1 | Conjugate X before use |
| cfg_conj_y | input | 1 | Conjugate Y before use |
| cfg_conj_z | input | 1 | Conjugate the result |
| cfg_divisor | input | 8 | Scalar divisor for mode 2 |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_re | output | 16 | Result real part, Q1.15 |
| out_im | output | 16 | Result imaginary part, Q1.15 |
| out_last | output | 1 | Last marker of this result |
| out_err | output | 1 | Divide-by-zero flag of this result |

## Verification
Product mode is driven through the full four-operand grid of eight corner values {−32768, −32767, −16384, −1, 0, 1, 16384, 32767}, under all eight conjugate settings. This grid separates a wrong sign in the cross terms, rounding in the wrong direction, wrapping where the result should clamp, and a conjugation applied at the wrong point. Both divide modes are swept over all 256 divisors with several X values. This checks every table entry and the zero-divisor override, and in scalar mode the Y inputs are varied to show they have no effect. A random product stream under random output throttling, together with a directed stall, separates correct handshake ordering from dropped or duplicated samples.

// File: rtl/cvmd_pkg.sv
`timescale 1ns/1ps
// Package for the complex multiply/divide unit: operation codes and the
// reciprocal-table value function shared by the design modules.
// Assumes divisors are unsigned integers and reciprocals carry FRAC fraction bits.
package cvmd_pkg;

    typedef enum logic [1:0] {
        OP_MUL     = 2'd0,
        OP_DIV_VEC = 2'd1,
        OP_DIV_SCL = 2'd2,
        OP_MUL_ALT = 2'd3
    } op_mode_e;

    // Rounded reciprocal of d with FRAC fraction bits; entry 0 is unused.
    function automatic int recip_value(input int d, input int frac);
        if (d == 0) return 0;
        return ((1 << frac) + d / 2) / d;
    endfunction

endpackage

// File: rtl/cvmd_recip_rom.sv
`timescale 1ns/1ps
// Inverse table: maps an unsigned divisor index to its rounded reciprocal
// in unsigned fixed point with DW fraction bits (1.0 is representable).
// Assumes DVW is small enough for a fully unrolled constant table.
module cvmd_recip_rom #(
    parameter int DW  = 16,
    parameter int DVW = 8
) (
    input  logic [DVW-1:0] idx,
    output logic [DW:0]    val
);
    import cvmd_pkg::*;

    localparam int DEPTH = 1 << DVW;

    logic [DW:0] table_w [DEPTH];

    // One constant entry per divisor value, computed at elaboration.
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        localparam int RV = recip_value(g, DW);
        assign table_w[g] = (DW+1)'(RV);
    end

    assign val = table_w[idx];

endmodule

// File: rtl/cvmd_prep.sv
`timescale 1ns/1ps
// Stage 1: applies the input conjugations, picks the divisor source by mode,
// looks up its reciprocal and registers operands plus sideband.
// Assumes adv is the common pipeline advance enable.
module cvmd_prep #(
    parameter int DW  = 16,
    parameter int DVW = 8
) (
    input  logic                 clk,
    input  logic                 adv,
    input  logic signed [DW-1:0] x_re,
    input  logic signed [DW-1:0] x_im,
    input  logic signed [DW-1:0] y_re,
    input  logic signed [DW-1:0] y_im,
    input  logic [1:0]           mode,
    input  logic                 conj_x,
    input  logic                 conj_y,
    input  logic                 conj_z,
    input  logic [DVW-1:0]       scl_div,
    input  logic                 last,
    output logic signed [DW-1:0] a_re,
    output logic signed [DW-1:0] a_im,
    output logic signed [DW-1:0] b_re,
    output logic signed [DW-1:0] b_im,
    output logic [DW:0]          rcp,
    output logic                 is_div,
    output logic                 div_zero,
    output logic                 cz_q,
    output logic                 last_q
);
    import cvmd_pkg::*;

    localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};

    op_mode_e              op;
    logic                  div_w;
    logic [DVW-1:0]        div_sel;
    logic [DW:0]           rcp_w;
    logic signed [DW-1:0]  xi_w;
    logic signed [DW-1:0]  yi_w;

    // Saturating negation: the most negative value maps to the most positive.
    function automatic logic signed [DW-1:0] neg_sat(input logic signed [DW-1:0] v);
        if (v == MINV) return MAXV;
        return -v;
    endfunction

    // Decode mode, choose divisor source and conjugate imaginary parts.
    always_comb begin
        op      = op_mode_e'(mode);
        div_w   = (op == OP_DIV_VEC) || (op == OP_DIV_SCL);
        div_sel = (op == OP_DIV_VEC) ? y_re[DVW-1:0] : scl_div;
        xi_w    = conj_x ? neg_sat(x_im) : x_im;
        yi_w    = conj_y ? neg_sat(y_im) : y_im;
    end

    cvmd_recip_rom #(.DW(DW), .DVW(DVW)) u_rom (
        .idx (div_sel),
        .val (rcp_w)
    );

    // Stage-1 register bank, loaded whenever the pipeline advances.
    always_ff @(posedge clk) begin
        if (adv) begin
            a_re     <= x_re;
            a_im     <= xi_w;
            b_re     <= y_re;
            b_im     <= yi_w;
            rcp      <= rcp_w;
            is_div   <= div_w;
            div_zero <= div_w && (div_sel == '0);
            cz_q     <= conj_z;
            last_q   <= last;
        end
    end

endmodule

// File: rtl/cvmd_mult.sv
`timescale 1ns/1ps
// Stage 2: forms the four partial products. Product mode uses the complex
// cross terms; divide mode scales both X parts by the unsigned reciprocal.
// Assumes PW is wide enough for a DW x (DW+2) signed product.
module cvmd_mult #(
    parameter int DW = 16,
    parameter int PW = 2*DW + 2
) (
    input  logic                 clk,
    input  logic                 adv,
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    input  logic [DW:0]          rcp,
    input  logic                 is_div,
    input  logic                 div_zero,
    input  logic                 cz,
    input  logic                 last,
    output logic signed [PW-1:0] p_rr,
    output logic signed [PW-1:0] p_ii,
    output logic signed [PW-1:0] p_ri,
    output logic signed [PW-1:0] p_ir,
    output logic                 is_div_q,
    output logic                 div_zero_q,
    output logic                 cz_q,
    output logic                 last_q
);
    logic signed [PW-1:0] ar, ai, br, bi, rc;

    // Extend operands to product width; the reciprocal is zero-extended.
    always_comb begin
        ar = PW'(a_re);
        ai = PW'(a_im);
        br = PW'(b_re);
        bi = PW'(b_im);
        rc = PW'(rcp);
    end

    // Stage-2 products and sideband, loaded whenever the pipeline advances.
    always_ff @(posedge clk) begin
        if (adv) begin
            if (is_div) begin
                p_rr <= ar * rc;
                p_ii <= '0;
                p_ri <= '0;
                p_ir <= ai * rc;
            end else begin
                p_rr <= ar * br;
                p_ii <= ai * bi;
                p_ri <= ar * bi;
                p_ir <= ai * br;
            end
            is_div_q   <= is_div;
            div_zero_q <= div_zero;
            cz_q       <= cz;
            last_q     <= last;
        end
    end

endmodule

// File: rtl/cvmd_round.sv
`timescale 1ns/1ps
// Stage 3: sums the partial products, rounds half-up back to Q1.15 (shift
// DW-1 for products, DW for divisions), saturates, applies the output
// conjugate and the divide-by-zero override, and registers the result.
module cvmd_round #(
    parameter int DW = 16,
    parameter int PW = 2*DW + 2
) (
    input  logic                 clk,
    input  logic                 adv,
    input  logic signed [PW-1:0] p_rr,
    input  logic signed [PW-1:0] p_ii,
    input  logic signed [PW-1:0] p_ri,
    input  logic signed [PW-1:0] p_ir,
    input  logic                 is_div,
    input  logic                 div_zero,
    input  logic                 cz,
    input  logic                 last,
    output logic signed [DW-1:0] z_re,
    output logic signed [DW-1:0] z_im,
    output logic                 z_last,
    output logic                 z_err
);
    localparam int SW = PW + 1;
    localparam logic signed [SW-1:0] BIAS_D = {{(SW-DW){1'b0}}, 1'b1, {(DW-1){1'b0}}};
    localparam logic signed [SW-1:0] BIAS_P = {{(SW-DW+1){1'b0}}, 1'b1, {(DW-2){1'b0}}};
    localparam logic signed [SW-1:0] HI_W   = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [SW-1:0] LO_W   = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};
    localparam logic signed [DW-1:0] MINV   = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [DW-1:0] MAXV   = {1'b0, {(DW-1){1'b1}}};

    logic signed [SW-1:0] s_re, s_im;
    logic signed [DW-1:0] r_re, r_im, f_im;

    // Round half-up by the mode's shift, then clamp to the Q1.15 range.
    function automatic logic signed [DW-1:0] round_sat(input logic signed [SW-1:0] v,
                                                       input logic dv);
        logic signed [SW-1:0] t;
        if (dv) t = (v + BIAS_D) >>> DW;
        else    t = (v + BIAS_P) >>> (DW-1);
        if (t > HI_W) return MAXV;
        if (t < LO_W) return MINV;
        return t[DW-1:0];
    endfunction

    // Combine partial products, round, and conjugate the result if asked.
    always_comb begin
        s_re = SW'(p_rr) - SW'(p_ii);
        s_im = SW'(p_ri) + SW'(p_ir);
        r_re = round_sat(s_re, is_div);
        r_im = round_sat(s_im, is_div);
        if (cz) f_im = (r_im == MINV) ? MAXV : -r_im;
        else    f_im = r_im;
    end

    // Output register; a zero divisor overrides the data with the maximum.
    always_ff @(posedge clk) begin
        if (adv) begin
            z_re   <= div_zero ? MAXV : r_re;
            z_im   <= div_zero ? MAXV : f_im;
            z_err  <= div_zero;
            z_last <= last;
        end
    end

endmodule

// File: rtl/cvec_muldiv.sv
`timescale 1ns/1ps
// Top of the component-wise complex multiply/divide unit. Three register
// stages (prep, multiply, round) share one advance enable, so the whole
// pipeline stalls when the result is valid and not taken.
// Assumes configuration inputs are sampled with each accepted sample.
module cvec_muldiv #(
    parameter int DW  = 16,
    parameter int DVW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_x_re,
    input  logic [DW-1:0] in_x_im,
    input  logic [DW-1:0] in_y_re,
    input  logic [DW-1:0] in_y_im,
    input  logic          in_last,
    input  logic [1:0]    cfg_mode,
    input  logic          cfg_conj_x,
    input  logic          cfg_conj_y,
    input  logic          cfg_conj_z,
    input  logic [DVW-1:0] cfg_divisor,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_re,
    output logic [DW-1:0] out_im,
    output logic          out_last,
    output logic          out_err
);
    localparam int PW     = 2*DW + 2;
    localparam int STAGES = 3;

    logic [STAGES-1:0] vld;
    logic              adv;

    logic signed [DW-1:0] a_re, a_im, b_re, b_im;
    logic [DW:0]          rcp;
    logic                 s1_div, s1_zero, s1_cz, s1_last;
    logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;
    logic                 s2_div, s2_zero, s2_cz, s2_last;
    logic signed [DW-1:0] z_re, z_im;

    assign adv       = !vld[STAGES-1] || out_ready;
    assign in_ready  = adv;
    assign out_valid = vld[STAGES-1];
    assign out_re    = z_re;
    assign out_im    = z_im;

    // Valid token chain, shifted forward whenever the pipeline advances.
    always_ff @(posedge clk) begin
        if (!rst_n)   vld <= '0;
        else if (adv) vld <= {vld[STAGES-2:0], in_valid};
    end

    cvmd_prep #(.DW(DW), .DVW(DVW)) u_prep (
        .clk      (clk),
        .adv      (adv),
        .x_re     ($signed(in_x_re)),
        .x_im     ($signed(in_x_im)),
        .y_re     ($signed(in_y_re)),
        .y_im     ($signed(in_y_im)),
        .mode     (cfg_mode),
        .conj_x   (cfg_conj_x),
        .conj_y   (cfg_conj_y),
        .conj_z   (cfg_conj_z),
        .scl_div  (cfg_divisor),
        .last     (in_last),
        .a_re     (a_re),
        .a_im     (a_im),
        .b_re     (b_re),
        .b_im     (b_im),
        .rcp      (rcp),
        .is_div   (s1_div),
        .div_zero (s1_zero),
        .cz_q     (s1_cz),
        .last_q   (s1_last)
    );

    cvmd_mult #(.DW(DW), .PW(PW)) u_mult (
        .clk        (clk),
        .adv        (adv),
        .a_re       (a_re),
        .a_im       (a_im),
        .b_re       (b_re),
        .b_im       (b_im),
        .rcp        (rcp),
        .is_div     (s1_div),
        .div_zero   (s1_zero),
        .cz         (s1_cz),
        .last       (s1_last),
        .p_rr       (p_rr),
        .p_ii       (p_ii),
        .p_ri       (p_ri),
        .p_ir       (p_ir),
        .is_div_q   (s2_div),
        .div_zero_q (s2_zero),
        .cz_q       (s2_cz),
        .last_q     (s2_last)
    );

    cvmd_round #(.DW(DW), .PW(PW)) u_round (
        .clk      (clk),
        .adv      (adv),
        .p_rr     (p_rr),
        .p_ii     (p_ii),
        .p_ri     (p_ri),
        .p_ir     (p_ir),
        .is_div   (s2_div),
        .div_zero (s2_zero),
        .cz       (s2_cz),
        .last     (s2_last),
        .z_re     (z_re),
        .z_im     (z_im),
        .z_last   (out_last),
        .z_err    (out_err)
    );

endmodule

// File: rtl/cvmd_checker.sv
`timescale 1ns/1ps
// Protocol checker for cvec_muldiv: tracks samples in flight at the ports
// and checks reset state, stall behaviour, occupancy and zero-divide output.
module cvmd_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_re,
    input logic [DW-1:0] out_im,
    input logic          out_last,
    input logic          out_err
);
    localparam logic [DW-1:0] SAT_MAX = {1'b0, {(DW-1){1'b1}}};

    logic [2:0] occ;

    // Samples accepted but not yet delivered, seen only at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= '0;
        else        occ <= occ + 3'(in_valid && in_ready) - 3'(out_valid && out_ready);
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && in_ready)); // R10

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)
                                        && $stable(out_last) && $stable(out_err))); // R9

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == 3'd3 && !out_ready) |-> !in_ready); // R9

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= 3'd3); // R8

    AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (occ != 3'd0)); // R8

    AST_ZERO_DIV_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (out_re == SAT_MAX && out_im == SAT_MAX)); // R7

endmodule

bind cvec_muldiv cvmd_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_re    (out_re),
    .out_im    (out_im),
    .out_last  (out_last),
    .out_err   (out_err)
);

// File: tb/sim_cvec_muldiv.sv
`timescale 1ns/1ps
module sim_cvec_muldiv;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_x_re = '0, in_x_im = '0, in_y_re = '0, in_y_im = '0;
    logic        in_last = 1'b0;
    logic [1:0]  cfg_mode = '0;
    logic        cfg_conj_x = 1'b0, cfg_conj_y = 1'b0, cfg_conj_z = 1'b0;
    logic [7:0]  cfg_divisor = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_re, out_im;
    logic        out_last, out_err;

    int n_tests = 0;
    int n_fail  = 0;
    int sample_no = 0;
    bit done = 1'b0;
    bit hold_stall = 1'b0;
    bit throttle = 1'b0;
    int unsigned seed = 32'h1234_5678;
    int unsigned seed_rdy = 32'h0bad_cafe;
    int vals [8];

    logic [33:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    cvec_muldiv u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_x_re(in_x_re), .in_x_im(in_x_im), .in_y_re(in_y_re), .in_y_im(in_y_im),
        .in_last(in_last), .cfg_mode(cfg_mode), .cfg_conj_x(cfg_conj_x),
        .cfg_conj_y(cfg_conj_y), .cfg_conj_z(cfg_conj_z), .cfg_divisor(cfg_divisor),
        .out_valid(out_valid), .out_ready(out_ready), .out_re(out_re), .out_im(out_im),
        .out_last(out_last), .out_err(out_err)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int unsigned nextr();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    function automatic longint sat16(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint negs(input longint v);
        return (v == -32768) ? 32767 : -v;
    endfunction

    // Reference model written from the requirements: {last, err, re, im}.
    function automatic logic [33:0] model(input longint xr, input longint xi,
                                          input longint yr, input longint yi,
                                          input int mode, input bit cx, input bit cy,
                                          input bit cz, input int dv, input bit last);
        longint re, im, d, r;
        bit err;
        err = 1'b0;
        if (cx) xi = negs(xi);
        if (cy) yi = negs(yi);
        if (mode == 1 || mode == 2) begin
            d = (mode == 1) ? (yr & 255) : longint'(dv);
            if (d == 0) begin
                re = 32767; im = 32767; err = 1'b1;
            end else begin
                r  = (65536 + d / 2) / d;
                re = sat16((xr * r + 32768) >>> 16);
                im = sat16((xi * r + 32768) >>> 16);
                if (cz) im = negs(im);
            end
        end else begin
            re = sat16((xr * yr - xi * yi + 16384) >>> 15);
            im = sat16((xr * yi + xi * yr + 16384) >>> 15);
            if (cz) im = negs(im);
        end
        return {last, err, re[15:0], im[15:0]};
    endfunction

    // Drive one sample (inputs change 1 ns after a rising edge) until accepted.
    task automatic send(input int xr, input int xi, input int yr, input int yi,
                        input int mode, input bit cx, input bit cy, input bit cz,
                        input int dv, input string tag);
        bit lst;
        lst = (sample_no % 5) == 4;
        sample_no++;
        in_x_re = 16'(xr); in_x_im = 16'(xi); in_y_re = 16'(yr); in_y_im = 16'(yi);
        cfg_mode = 2'(mode); cfg_conj_x = cx; cfg_conj_y = cy; cfg_conj_z = cz;
        cfg_divisor = 8'(dv); in_last = lst; in_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (in_ready) begin
                exp_q.push_back(model(xr, xi, $signed(16'(yr)), yi, mode, cx, cy, cz, dv, lst));
                tag_q.push_back(tag);
                @(posedge clk); #1;
                in_valid = 1'b0;
                break;
            end
            @(posedge clk); #1;
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    // Output-ready generator: stall, random throttle or always ready.
    always @(posedge clk) begin
        #1;
        seed_rdy = seed_rdy * 32'd22695477 + 32'd1;
        if (hold_stall)    out_ready = 1'b0;
        else if (throttle) out_ready = seed_rdy[16];
        else               out_ready = 1'b1;
    end

    // Result monitor: every delivered result is compared in order (R8).
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8", "unexpected result", {out_last, out_err, out_re, out_im}, 0);
            end else begin
                logic [33:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({out_last, out_err, out_re, out_im} == e, t,
                    "result {last,err,re,im}", {out_last, out_err, out_re, out_im}, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int acc;
        logic [15:0] hold_re;
        vals = '{-32768, -32767, -16384, -1, 0, 1, 16384, 32767};

        // R10: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
        chk(in_ready == 1'b1, "R10", "in_ready in reset", in_ready, 1);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;

        // R8: latency of a single sample
        send(1000, -2000, 16384, 0, 0, 0, 0, 0, 0, "R8");
        @(negedge clk);
        chk(out_valid == 1'b0, "R8", "valid after 1 edge", out_valid, 0);
        @(negedge clk);
        chk(out_valid == 1'b0, "R8", "valid after 2 edges", out_valid, 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R8", "valid after 3 edges", out_valid, 1);
        drain();

        // R2: (-1)*(-1) saturates
        send(-32768, 0, -32768, 0, 0, 0, 0, 0, 0, "R2");
        send(-32768, -32768, -32768, 32767, 0, 0, 0, 0, 0, "R2");

        // R1, R3, R4: full corner grid under every conjugate setting
        for (int c = 0; c < 8; c++)
            for (int a = 0; a < 8; a++)
                for (int b = 0; b < 8; b++)
                    for (int p = 0; p < 8; p++)
                        for (int q = 0; q < 8; q++)
                            send(vals[a], vals[b], vals[p], vals[q], 0,
                                 c[0], c[1], c[2], 0,
                                 c[2] ? "R4" : ((c[1:0] != 0) ? "R3" : "R1"));

        // R11: mode 3 matches product mode
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++)
                for (int p = 0; p < 8; p++)
                    for (int q = 0; q < 8; q++)
                        send(vals[a], vals[b], vals[p], vals[q], 3, 0, 0, 0, 0, "R11");

        // R1, R8: random products under random output throttling
        throttle = 1'b1;
        for (int k = 0; k < 2000; k++) begin
            int unsigned r1, r2;
            r1 = nextr(); r2 = nextr();
            send($signed(r1[15:0]), $signed(r1[31:16]), $signed(r2[15:0]),
                 $signed(r2[31:16]), 0, 0, 0, 0, 0, "R1");
        end
        throttle = 1'b0;

        // R5, R7: vector divisor taken from in_y_re[7:0], all 256 values
        for (int d = 0; d < 256; d++)
            for (int i = 0; i < 8; i++) begin
                int unsigned r;
                r = nextr();
                send(vals[i], vals[7-i], int'({r[7:0], 8'(d)}) - ((r[7]) ? 65536 : 0),
                     $signed(r[31:16]), 1, i[0], 0, i[1], 0, (d == 0) ? "R7" : "R5");
            end

        // R6, R7: scalar divisor, Y inputs varied and ignored
        for (int d = 0; d < 256; d++)
            for (int i = 0; i < 8; i++) begin
                int unsigned r;
                r = nextr();
                send(vals[7-i], vals[i], $signed(r[15:0]), $signed(r[31:16]), 2,
                     i[1], i[0], i[2], d, (d == 0) ? "R7" : "R6");
            end
        drain();

        // R9: stall from empty, exactly three accepted, outputs held
        hold_stall = 1'b1;
        @(posedge clk); #1;
        acc = 0;
        for (int k = 0; k < 6; k++) begin
            bit lst;
            lst = (sample_no % 5) == 4;
            sample_no++;
            in_x_re = 16'(100 * (k + 1)); in_x_im = 16'(-50 * k);
            in_y_re = 16'(8192); in_y_im = 16'(4096);
            cfg_mode = 2'd0; cfg_conj_x = 0; cfg_conj_y = 0; cfg_conj_z = 0;
            in_last = lst; in_valid = 1'b1;
            @(negedge clk);
            if (in_ready) begin
                acc++;
                exp_q.push_back(model(100 * (k + 1), -50 * k, 8192, 4096, 0, 0, 0, 0, 0, lst));
                tag_q.push_back("R9");
            end
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        chk(acc == 3, "R9", "samples accepted under stall", acc, 3);
        @(negedge clk);
        chk(in_ready == 1'b0, "R9", "in_ready when full", in_ready, 0);
        chk(out_valid == 1'b1, "R9", "out_valid when full", out_valid, 1);
        hold_re = out_re;
        @(negedge clk);
        chk(out_re == hold_re, "R9", "out_re held", out_re, hold_re);
        hold_stall = 1'b0;
        drain();
        chk(exp_q.size() == 0, "R8", "all results delivered", exp_q.size(), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule